// File: doc/BRIEF.md
# Granule-Based Load-Linked Reservation Monitor

This block serves a small shared-memory system in which several requester ports reach one word-addressed memory. The low-numbered ports are processors and the rest are IO masters. Every port can issue a plain load, a plain store, a load-linked or a store-conditional in any cycle. Each request is taken in the cycle it is presented. Load data and the store-conditional result come back combinationally in that same cycle, and any write lands at the next rising clock edge.

Each processor port holds one hidden reservation: a flag plus the granule index of its last load-linked. The monitor snoops every write attempt from every port. It clears a reservation whenever a write touches the reserved aligned granule, and it lets a store-conditional reach memory only while the issuer's flag is still set. The granule is a power-of-two number of bytes, so a write to any word of that aligned region breaks the reservation, even a write by another processor's successful store-conditional. When several writes fall into one granule in the same cycle, the lowest-numbered port wins.

Top module: `rsv_monitor`

## Requirements
- R1: A load or load-linked returns, in the same cycle, the memory word at `req_addr`, which is a word index. A write is seen by reads from the cycle after its clock edge.
- R2: A load-linked on a processor port sets that port's reservation. A store-conditional issued next with no intervening write to the granule reports `rsp_sc_ok`=1 and writes its data.
- R3: A store-conditional from a processor port whose reservation flag is clear reports 0, and the memory stays unchanged.
- R4: A plain store from any port, processor or IO, to any word of a reserved granule clears that reservation. A later store-conditional then reports 0.
- R5: A successful store-conditional by one processor clears another processor's reservation in the same granule. This holds whichever of the two load-linked operations came first.
- R6: Granule index = word address >> log2(GRAN_BYTES / bytes per word). A store to a different granule leaves a reservation intact; with the default 8-byte granule and 4-byte words, word 6 does not disturb word 4.
- R7: A store-conditional always clears its issuing port's own reservation, whether it succeeds or fails.
- R8: A new load-linked replaces the port's previous reserved granule. Writes to the old granule then no longer break the reservation.
- R9: When several write attempts (stores, or store-conditionals with the flag set) fall in one granule in the same cycle, only the lowest-numbered port writes. The other store-conditionals report 0, and every reservation covering that granule is cleared. Writes to different granules in one cycle all land.
- R10: `rsp_sc_ok` is 1 for success and 0 for failure. A store-conditional from an IO port always reports 0 and never writes.
- R11: Synchronous active-high reset clears every reservation flag and sets every memory word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request present on each port |
| req_op | input | NPORT x 2 | Operation per port: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | NPORT x ADDR_W | Word address per port |
| req_wdata | input | NPORT x DATA_W | Write data per port |
| rsp_rdata | output | NPORT x DATA_W | Memory word at each port's address, same cycle |
| rsp_sc_ok | output | NPORT | Store-conditional success flag, same cycle |

## Verification
On every cycle the assertions check four properties. A store-conditional succeeds only while its issuer holds a reservation. Every store-conditional leaves its issuer's flag clear. IO ports never report success. Two same-cycle store-conditionals in one granule never both succeed. They also check that another processor's successful store-conditional into a reserved granule drops that reservation, and that reset empties every flag. Only the bench's scenarios can show the effects that reach memory: data landing or being suppressed, the two load-linked orderings, the granule boundary, the replacement of a reservation, the choice of winner among same-cycle stores, and memory cleared by reset.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } rsv_op_e;

    // A request wants to write when it is a store, or a store-conditional
    // whose issuer still holds a reservation.
    function automatic logic write_intent(input logic vld, input logic [1:0] op,
                                          input logic has_res);
        return vld && ((op == OP_STORE) || ((op == OP_SC) && has_res));
    endfunction

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rsv_wr_arb.sv
module rsv_wr_arb
    import rsv_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NPROC = 2,
    parameter int GW    = 5
) (
    input  logic [NPORT-1:0]         req_valid,
    input  logic [NPORT-1:0][1:0]    req_op,
    input  logic [NPORT-1:0][GW-1:0] req_gran,
    input  logic [NPROC-1:0]         res_valid,
    output logic [NPORT-1:0]         wants,
    output logic [NPORT-1:0]         grant
);

    for (genvar i = 0; i < NPORT; i++) begin : g_want
        if (i < NPROC) begin : g_proc
            assign wants[i] = write_intent(req_valid[i], req_op[i], res_valid[i]);
        end else begin : g_io
            assign wants[i] = write_intent(req_valid[i], req_op[i], 1'b0);
        end
    end

    // Fixed priority inside a granule: a lower port blocks a higher one.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            grant[i] = wants[i];
            for (int j = 0; j < i; j++) begin
                if (wants[j] && (req_gran[j] == req_gran[i])) begin
                    grant[i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int GW    = 5,
    parameter int IDX   = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     my_valid,
    input  logic [1:0]               my_op,
    input  logic [NPORT-1:0]         wants,
    input  logic [NPORT-1:0][GW-1:0] gran_all,
    output logic                     res_valid,
    output logic [GW-1:0]            res_gran
);

    logic hit_cur;
    logic hit_new;

    // Any write attempt into the held granule, or into the one being reserved now.
    always_comb begin
        hit_cur = 1'b0;
        hit_new = 1'b0;
        for (int j = 0; j < NPORT; j++) begin
            if (wants[j] && (gran_all[j] == res_gran))      hit_cur = 1'b1;
            if (wants[j] && (gran_all[j] == gran_all[IDX])) hit_new = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_gran  <= '0;
        end else if (my_valid && (my_op == OP_LL)) begin
            res_valid <= !hit_new;
            res_gran  <= gran_all[IDX];
        end else if (my_valid && (my_op == OP_SC)) begin
            res_valid <= 1'b0;
        end else if (hit_cur) begin
            res_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/rsv_mem.sv
module rsv_mem #(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][DATA_W-1:0] wdata,
    output logic [NPORT-1:0][DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata[p] = words[addr[p]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) words[k] <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (we[p]) words[addr[p]] <= wdata[p];
            end
        end
    end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int NPROC      = 2,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int GRAN_BYTES = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             req_valid,
    input  logic [NPORT-1:0][1:0]        req_op,
    input  logic [NPORT-1:0][ADDR_W-1:0] req_addr,
    input  logic [NPORT-1:0][DATA_W-1:0] req_wdata,
    output logic [NPORT-1:0][DATA_W-1:0] rsp_rdata,
    output logic [NPORT-1:0]             rsp_sc_ok
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int GSH        = $clog2(GRAN_BYTES) - $clog2(WORD_BYTES);
    localparam int GW         = ADDR_W - GSH;

    if (!is_pow2(GRAN_BYTES) || GRAN_BYTES < 8 || GRAN_BYTES > 2048 ||
        GRAN_BYTES < WORD_BYTES || GSH >= ADDR_W || NPROC > NPORT) begin : g_bad_param
        $error("rsv_monitor: unsupported parameter set");
    end

    logic [NPORT-1:0][GW-1:0]  req_gran;
    logic [NPROC-1:0]          res_valid;
    logic [NPROC-1:0][GW-1:0]  res_gran;
    logic [NPORT-1:0]          wants;
    logic [NPORT-1:0]          grant;

    for (genvar p = 0; p < NPORT; p++) begin : g_gran
        assign req_gran[p]  = req_addr[p][ADDR_W-1:GSH];
        assign rsp_sc_ok[p] = req_valid[p] && (req_op[p] == OP_SC) && grant[p];
    end

    rsv_wr_arb #(.NPORT(NPORT), .NPROC(NPROC), .GW(GW)) u_arb (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_gran  (req_gran),
        .res_valid (res_valid),
        .wants     (wants),
        .grant     (grant)
    );

    for (genvar p = 0; p < NPROC; p++) begin : g_slot
        rsv_slot #(.NPORT(NPORT), .GW(GW), .IDX(p)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .my_valid  (req_valid[p]),
            .my_op     (req_op[p]),
            .wants     (wants),
            .gran_all  (req_gran),
            .res_valid (res_valid[p]),
            .res_gran  (res_gran[p])
        );
    end

    rsv_mem #(.NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .addr  (req_addr),
        .we    (grant),
        .wdata (req_wdata),
        .rdata (rsp_rdata)
    );

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk
    import rsv_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NPROC = 2,
    parameter int GW    = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NPORT-1:0]         req_valid,
    input logic [NPORT-1:0][1:0]    req_op,
    input logic [NPORT-1:0][GW-1:0] req_gran,
    input logic [NPROC-1:0]         res_valid,
    input logic [NPROC-1:0][GW-1:0] res_gran,
    input logic [NPORT-1:0]         sc_ok
);

    a_r11_reset_clears: assert property (@(posedge clk) rst |=> (res_valid == '0));

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        a_r3_sc_needs_res: assert property (@(posedge clk) disable iff (rst)
            sc_ok[p] |-> res_valid[p]);

        a_r7_sc_self_clear: assert property (@(posedge clk) disable iff (rst)
            (req_valid[p] && req_op[p] == OP_SC) |=> !res_valid[p]);

        for (genvar q = 0; q < NPROC; q++) begin : g_other
            if (q != p) begin : g_ne
                a_r5_peer_sc_breaks: assert property (@(posedge clk) disable iff (rst)
                    (sc_ok[q] && res_valid[p] && req_gran[q] == res_gran[p] &&
                     !(req_valid[p] && req_op[p] == OP_LL)) |=> !res_valid[p]);
            end
        end
    end

    for (genvar i = NPROC; i < NPORT; i++) begin : g_io
        a_r10_io_sc_fails: assert property (@(posedge clk) disable iff (rst) !sc_ok[i]);
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_pi
        for (genvar j = i + 1; j < NPORT; j++) begin : g_pj
            a_r9_single_winner: assert property (@(posedge clk) disable iff (rst)
                (req_gran[i] == req_gran[j]) |-> !(sc_ok[i] && sc_ok[j]));
        end
    end

endmodule

bind rsv_monitor rsv_monitor_chk #(.NPORT(NPORT), .NPROC(NPROC), .GW(GW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_gran  (req_gran),
    .res_valid (res_valid),
    .res_gran  (res_gran),
    .sc_ok     (rsp_sc_ok)
);

// File: tb/tb_rsv_monitor.sv
module tb_rsv_monitor;

    localparam int CLK_P  = 10;
    localparam int NPORT  = 4;
    localparam int NPROC  = 2;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;
    localparam logic [1:0] CK_NONE = 2'd0, CK_DATA = 2'd1, CK_OK = 2'd2;

    typedef struct packed {
        logic [1:0]  port;
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [1:0]  chk;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{2'd0, LD, 6'd4,  32'h0,        32'h0,        CK_DATA, 8'd11}, // R11 memory zero after reset
        '{2'd0, ST, 6'd4,  32'hAAAA0001, 32'h0,        CK_NONE, 8'd1},
        '{2'd1, LD, 6'd4,  32'h0,        32'hAAAA0001, CK_DATA, 8'd1},  // R1 read after write
        '{2'd0, LL, 6'd4,  32'h0,        32'hAAAA0001, CK_DATA, 8'd2},  // R2 LL returns word
        '{2'd0, SC, 6'd4,  32'h11,       32'h1,        CK_OK,   8'd2},  // R2 success
        '{2'd0, LD, 6'd4,  32'h0,        32'h11,       CK_DATA, 8'd2},
        '{2'd0, SC, 6'd4,  32'h22,       32'h0,        CK_OK,   8'd7},  // R7 own flag gone
        '{2'd0, LD, 6'd4,  32'h0,        32'h11,       CK_DATA, 8'd3},  // R3 unchanged
        '{2'd1, SC, 6'd8,  32'h33,       32'h0,        CK_OK,   8'd3},  // R3 never reserved
        '{2'd1, LD, 6'd8,  32'h0,        32'h0,        CK_DATA, 8'd3},
        '{2'd0, LL, 6'd4,  32'h0,        32'h0,        CK_NONE, 8'd4},
        '{2'd2, ST, 6'd5,  32'h44,       32'h0,        CK_NONE, 8'd4},  // R4 IO store same granule
        '{2'd0, SC, 6'd4,  32'h55,       32'h0,        CK_OK,   8'd4},
        '{2'd0, LD, 6'd4,  32'h0,        32'h11,       CK_DATA, 8'd4},
        '{2'd0, LL, 6'd4,  32'h0,        32'h0,        CK_NONE, 8'd6},
        '{2'd3, ST, 6'd6,  32'h66,       32'h0,        CK_NONE, 8'd6},  // R6 next granule
        '{2'd0, SC, 6'd4,  32'h77,       32'h1,        CK_OK,   8'd6},
        '{2'd1, LD, 6'd6,  32'h0,        32'h66,       CK_DATA, 8'd6},
        '{2'd0, LL, 6'd4,  32'h0,        32'h0,        CK_NONE, 8'd5},  // R5 order A first
        '{2'd1, LL, 6'd5,  32'h0,        32'h0,        CK_NONE, 8'd5},
        '{2'd1, SC, 6'd5,  32'h88,       32'h1,        CK_OK,   8'd5},
        '{2'd0, SC, 6'd4,  32'h99,       32'h0,        CK_OK,   8'd5},
        '{2'd1, LL, 6'd5,  32'h0,        32'h0,        CK_NONE, 8'd5},  // R5 order B first
        '{2'd0, LL, 6'd4,  32'h0,        32'h0,        CK_NONE, 8'd5},
        '{2'd1, SC, 6'd5,  32'hAB,       32'h1,        CK_OK,   8'd5},
        '{2'd0, SC, 6'd4,  32'hCD,       32'h0,        CK_OK,   8'd5},
        '{2'd0, LD, 6'd5,  32'h0,        32'hAB,       CK_DATA, 8'd5},
        '{2'd0, LD, 6'd4,  32'h0,        32'h77,       CK_DATA, 8'd5},
        '{2'd0, LL, 6'd4,  32'h0,        32'h0,        CK_NONE, 8'd8},  // R8 replace
        '{2'd0, LL, 6'd12, 32'h0,        32'h0,        CK_NONE, 8'd8},
        '{2'd2, ST, 6'd4,  32'hEE,       32'h0,        CK_NONE, 8'd8},
        '{2'd0, SC, 6'd12, 32'hF0,       32'h1,        CK_OK,   8'd8},
        '{2'd0, LD, 6'd12, 32'h0,        32'hF0,       CK_DATA, 8'd8},
        '{2'd0, LL, 6'd12, 32'h0,        32'h0,        CK_NONE, 8'd4},  // R4 processor store
        '{2'd1, ST, 6'd13, 32'h12345678, 32'h0,        CK_NONE, 8'd4},
        '{2'd0, SC, 6'd12, 32'hF1,       32'h0,        CK_OK,   8'd4},
        '{2'd0, LD, 6'd12, 32'h0,        32'hF0,       CK_DATA, 8'd4},
        '{2'd2, LL, 6'd16, 32'h0,        32'h0,        CK_NONE, 8'd10}, // R10 IO SC
        '{2'd2, SC, 6'd16, 32'h1,        32'h0,        CK_OK,   8'd10},
        '{2'd2, LD, 6'd16, 32'h0,        32'h0,        CK_DATA, 8'd10},
        '{2'd3, SC, 6'd17, 32'h2,        32'h0,        CK_OK,   8'd10}
    };

    logic                         clk = 1'b0;
    logic                         rst;
    logic [NPORT-1:0]             req_valid;
    logic [NPORT-1:0][1:0]        req_op;
    logic [NPORT-1:0][ADDR_W-1:0] req_addr;
    logic [NPORT-1:0][DATA_W-1:0] req_wdata;
    logic [NPORT-1:0][DATA_W-1:0] rsp_rdata;
    logic [NPORT-1:0]             rsp_sc_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    rsv_monitor #(.NPORT(NPORT), .NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .GRAN_BYTES(8)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        req_valid = '0;
        req_op    = '0;
        req_addr  = '0;
        req_wdata = '0;
    endtask

    task automatic set_port(input int p, input logic [1:0] op, input logic [5:0] a,
                            input logic [31:0] d);
        req_valid[p] = 1'b1;
        req_op[p]    = op;
        req_addr[p]  = a;
        req_wdata[p] = d;
    endtask

    // Inputs change at the falling edge; outputs are sampled 1 time unit
    // before the rising edge that commits the request.
    task automatic begin_cycle();
        @(negedge clk);
        idle_all();
    endtask

    task automatic sample_point();
        #(CLK_P/2 - 1);
    endtask

    task automatic one_op(input int p, input logic [1:0] op, input logic [5:0] a,
                          input logic [31:0] d);
        begin_cycle();
        set_port(p, op, a, d);
        sample_point();
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_all();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            one_op(int'(VECS[v].port), VECS[v].op, VECS[v].addr, VECS[v].wd);
            if (VECS[v].chk == CK_DATA)
                check($sformatf("R%0d vec%0d rdata", VECS[v].req, v),
                      rsp_rdata[VECS[v].port], VECS[v].exp);
            else if (VECS[v].chk == CK_OK)
                check($sformatf("R%0d vec%0d sc_ok", VECS[v].req, v),
                      {31'd0, rsp_sc_ok[VECS[v].port]}, VECS[v].exp);
        end

        // R9: two reserved SCs in one granule, same cycle
        one_op(0, LL, 6'd20, 32'h0);
        one_op(1, LL, 6'd21, 32'h0);
        begin_cycle();
        set_port(0, SC, 6'd20, 32'h1);
        set_port(1, SC, 6'd21, 32'h2);
        sample_point();
        check("R9 low port sc_ok", {31'd0, rsp_sc_ok[0]}, 32'h1);
        check("R9 high port sc_ok", {31'd0, rsp_sc_ok[1]}, 32'h0);
        one_op(2, LD, 6'd21, 32'h0);
        check("R9 loser data dropped", rsp_rdata[2], 32'h0);
        one_op(2, LD, 6'd20, 32'h0);
        check("R9 winner data", rsp_rdata[2], 32'h1);

        // R9: same-cycle stores; one granule collides, another is separate
        begin_cycle();
        set_port(2, ST, 6'd24, 32'h5);
        set_port(3, ST, 6'd25, 32'h6);
        set_port(1, ST, 6'd28, 32'h7);
        sample_point();
        one_op(0, LD, 6'd25, 32'h0);
        check("R9 store loser dropped", rsp_rdata[0], 32'h0);
        one_op(0, LD, 6'd24, 32'h0);
        check("R9 store winner", rsp_rdata[0], 32'h5);
        one_op(0, LD, 6'd28, 32'h0);
        check("R9 other granule lands", rsp_rdata[0], 32'h7);

        // R9: a losing attempt still clears reservations in that granule
        one_op(1, LL, 6'd31, 32'h0);
        begin_cycle();
        set_port(2, ST, 6'd30, 32'h8);
        set_port(3, ST, 6'd31, 32'h9);
        sample_point();
        one_op(1, SC, 6'd31, 32'hA);
        check("R9 reservation cleared", {31'd0, rsp_sc_ok[1]}, 32'h0);

        // R11: reset drops a live reservation and clears memory
        one_op(0, LL, 6'd32, 32'h0);
        begin_cycle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sample_point();
        one_op(0, SC, 6'd32, 32'hB);
        check("R11 flag cleared by reset", {31'd0, rsp_sc_ok[0]}, 32'h0);
        one_op(1, LD, 6'd4, 32'h0);
        check("R11 memory cleared by reset", rsp_rdata[1], 32'h0);

        begin_cycle();
        @(posedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule